// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host side of a PS/2 keyboard or mouse link. Software sees a small register window: a control register, a status register and a data/shift register. The port runs the open-drain clock and data lines through two active-low pull-down outputs. Whenever no transfer is enabled, the port holds the clock line low so that the device cannot send.

Software enables a receive or a transmit by writing a control bit. The port then releases the clock line, moves one 11-bit frame, and raises completion status. The enable bit clears itself at the end of the frame, so the line goes back to the inhibited state without another write. A transfer can be cancelled in two ways: by writing the abort-request bit, or by writing zero to every control bit while a transfer is enabled. Either way the port ends inhibited, with both the completion and abort flags set.

The register offsets are: 0 = control, 1 = status, 2 = data. Reads are combinational from `reg_addr`, and offset 3 reads 0.

Top module: `ps2_host_port`

## Requirements
- R1: After reset the control and status registers read 0x00, `clk_pull_low` is 1 (clock inhibited) and `dat_pull_low` is 0.
- R2: Control bit 0 is receive-enable, bit 1 is transmit-enable and bit 2 is abort-request. Bits 7..3 are ignored on write and read as 0. The abort-request bit always reads 0.
- R3: Writing control with bit 0 set and bits 1 and 2 clear, while idle, releases the clock line (`clk_pull_low` = 0) from the next cycle on.
- R4: While receive is enabled, the port samples data on each synchronized falling edge of the device clock. A frame is start, eight data bits LSB first, odd parity, stop. After the 11th bit the received byte reads at offset 2, receive-enable clears, status bit 0 (done) sets, and the clock is pulled low again.
- R5: A frame with a wrong odd-parity bit, or with a stop bit of 0, sets status bit 2 (error) together with done.
- R6: Writing control bit 1 while idle first holds the clock low for `INHIBIT_CYCLES` system cycles. The port then pulls data low (start bit) and releases the clock.
- R7: During a transmit, the port changes the data line after each device falling edge. It sends the data byte of offset 2 LSB first, then odd parity, then a released (high) stop bit.
- R8: On the 11th device falling edge of a transmit, the port samples the acknowledge. A high data line sets error. Transmit-enable clears, done sets, and the clock is pulled low.
- R9: Writing control with bit 2 set aborts any transfer. From the next cycle, status reads 0x03 (done and abort, status bit 1), both enables are clear, the clock is pulled low and data is released.
- R10: A control write with bits 2..0 all zero while a transfer is enabled acts as an abort, with the same result as R9.
- R11: Starting a transfer clears status to 0. While a transfer is enabled, writes to offset 2 and control writes that neither abort nor cancel leave the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset (0 control, 1 status, 2 data) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `reg_addr` |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock line |
| ps2_dat_in | input | 1 | Sensed level of the PS/2 data line |
| clk_pull_low | output | 1 | 1 pulls the PS/2 clock line low |
| dat_pull_low | output | 1 | 1 pulls the PS/2 data line low |

## Verification
A wrong bit counter or an edge detector that misses an edge shows up as a byte at offset 2 that is shifted or misaligned. It can also show up as a done flag that never rises, which leaves the clock released. Both are visible within the frame that caused them. A broken enable self-clear or abort path leaves the clock line released one cycle after the frame or abort. The bench reads that line directly, together with the status bits. On transmit, a device model captures every bit from the data line and compares it against the frame queued by the driver. Any wrong parity or ordering therefore fails on that same frame.

// File: rtl/ps2_pkg.sv
package ps2_pkg;
    localparam int FRAME_BITS = 11;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int TX_BITS    = 10;

    typedef struct packed {
        logic abort_req;
        logic tx_en;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic err;
        logic aborted;
        logic done;
    } stat_t;

    typedef enum logic [1:0] {TX_IDLE, TX_HOLD, TX_SEND, TX_END} tx_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction
endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] fell
);
    logic [W-1:0] s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '1;
            s2 <= '1;
            s3 <= '1;
        end else begin
            s1 <= raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign level = s2;
    assign fell  = s3 & ~s2;
endmodule

// File: rtl/ps2_rx.sv
module ps2_rx
    import ps2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       fall,
    input  logic       dat,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       rx_err
);
    logic [FRAME_BITS-1:0] sr;
    logic [CNT_W-1:0]      cnt;
    logic                  held;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sr   <= '0;
            cnt  <= '0;
            held <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (fall && !held) begin
                sr <= {dat, sr[FRAME_BITS-1:1]};
                if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                    cnt  <= '0;
                    done <= 1'b1;
                    held <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign rx_byte = sr[8:1];
    assign rx_err  = (sr[9] != odd_par(sr[8:1])) | ~sr[10];

    // R4
    rx_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_BITS - 1));
endmodule

// File: rtl/ps2_tx.sv
module ps2_tx
    import ps2_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       fall,
    input  logic       dat,
    input  logic [7:0] tx_byte,
    output logic       clk_low,
    output logic       dat_low,
    output logic       done,
    output logic       ack_err
);
    localparam int WAIT_W = $clog2(INHIBIT_CYCLES + 1);

    tx_state_t         state;
    logic [WAIT_W-1:0] wcnt;
    logic [CNT_W-1:0]  bcnt;
    logic [TX_BITS-1:0] payload;

    assign payload = {1'b1, odd_par(tx_byte), tx_byte};
    assign clk_low = (state != TX_SEND);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= TX_IDLE;
            wcnt    <= '0;
            bcnt    <= '0;
            dat_low <= 1'b0;
            done    <= 1'b0;
            ack_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    state <= TX_HOLD;
                    wcnt  <= '0;
                end
                TX_HOLD: begin
                    if (wcnt == WAIT_W'(INHIBIT_CYCLES - 1)) begin
                        state   <= TX_SEND;
                        dat_low <= 1'b1;
                        bcnt    <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                TX_SEND: begin
                    if (fall) begin
                        if (bcnt == CNT_W'(TX_BITS)) begin
                            ack_err <= dat;
                            done    <= 1'b1;
                            dat_low <= 1'b0;
                            state   <= TX_END;
                        end else begin
                            dat_low <= ~payload[bcnt];
                            bcnt    <= bcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    tx_hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_HOLD) |-> !dat_low);

    // R8
    tx_done_once_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
    import ps2_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       clk_pull_low,
    output logic       dat_pull_low
);
    ctrl_t      ctrl_q;
    stat_t      stat_q;
    logic [7:0] shift_q;

    logic [1:0] lvl, fell;
    logic       rx_done, rx_err, tx_done, ack_err, tx_clk_low, tx_dat_low;
    logic [7:0] rx_byte;

    ps2_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   ({ps2_dat_in, ps2_clk_in}),
        .level (lvl),
        .fell  (fell)
    );

    ps2_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.rx_en),
        .fall    (fell[0]),
        .dat     (lvl[1]),
        .done    (rx_done),
        .rx_byte (rx_byte),
        .rx_err  (rx_err)
    );

    ps2_tx #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.tx_en),
        .fall    (fell[0]),
        .dat     (lvl[1]),
        .tx_byte (shift_q),
        .clk_low (tx_clk_low),
        .dat_low (tx_dat_low),
        .done    (tx_done),
        .ack_err (ack_err)
    );

    logic  ctrl_wr, busy, abort_req, start_tx, start_rx;
    ctrl_t wr_ctrl;

    assign wr_ctrl   = ctrl_t'(wr_data[2:0]);
    assign ctrl_wr   = wr_en && (reg_addr == ADDR_CTRL);
    assign busy      = ctrl_q.rx_en | ctrl_q.tx_en;
    assign abort_req = ctrl_wr && (wr_ctrl.abort_req || (wr_data[2:0] == 3'b000 && busy));
    assign start_tx  = ctrl_wr && !busy && !wr_ctrl.abort_req && wr_ctrl.tx_en;
    assign start_rx  = ctrl_wr && !busy && !wr_ctrl.abort_req && !wr_ctrl.tx_en && wr_ctrl.rx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stat_q  <= '0;
            shift_q <= '0;
        end else begin
            if (abort_req) begin
                ctrl_q <= '0;
                stat_q <= '{err: 1'b0, aborted: 1'b1, done: 1'b1};
            end else if (start_tx) begin
                ctrl_q.tx_en <= 1'b1;
                stat_q       <= '0;
            end else if (start_rx) begin
                ctrl_q.rx_en <= 1'b1;
                stat_q       <= '0;
            end else if (rx_done && ctrl_q.rx_en) begin
                ctrl_q.rx_en <= 1'b0;
                stat_q       <= '{err: rx_err, aborted: 1'b0, done: 1'b1};
                shift_q      <= rx_byte;
            end else if (tx_done && ctrl_q.tx_en) begin
                ctrl_q.tx_en <= 1'b0;
                stat_q       <= '{err: ack_err, aborted: 1'b0, done: 1'b1};
            end
            if (wr_en && reg_addr == ADDR_DATA && !busy) begin
                shift_q <= wr_data;
            end
        end
    end

    assign clk_pull_low = ctrl_q.tx_en ? tx_clk_low : ~ctrl_q.rx_en;
    assign dat_pull_low = ctrl_q.tx_en & tx_dat_low;

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: rd_data = {6'b0, ctrl_q.tx_en, ctrl_q.rx_en};
            ADDR_STAT: rd_data = {5'b0, stat_q};
            ADDR_DATA: rd_data = shift_q;
            default:   rd_data = 8'h00;
        endcase
    end

    // R2
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_q.rx_en && ctrl_q.tx_en));

    // R4
    rx_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && ctrl_q.rx_en && !abort_req) |=> (!ctrl_q.rx_en && stat_q.done && clk_pull_low));

    // R9
    abort_result_chk: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (stat_q.done && stat_q.aborted && !busy && clk_pull_low && !dat_pull_low));

    // R11
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (start_tx || start_rx) |=> (stat_q == '0));
endmodule

// File: tb/sim_ps2_host_port.sv
module sim_ps2_host_port;
    localparam int INH = 40;
    localparam int H   = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       clk_pull_low, dat_pull_low;
    logic       dev_clk_low = 1'b0, dev_dat_low = 1'b0;
    logic       ps2_clk_line, ps2_dat_line;

    int n_checks = 0, n_fail = 0, frames_seen = 0;
    logic dev_ack = 1'b1;
    logic [9:0] exp_q[$];

    always #10 clk = ~clk;

    assign ps2_clk_line = !(clk_pull_low || dev_clk_low);
    assign ps2_dat_line = !(dat_pull_low || dev_dat_low);

    ps2_host_port #(.INHIBIT_CYCLES(INH)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ps2_clk_in(ps2_clk_line), .ps2_dat_in(ps2_dat_line),
        .clk_pull_low(clk_pull_low), .dat_pull_low(dat_pull_low)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    task automatic dev_send(input logic [7:0] b, input logic bad_par, input logic bad_stop);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            dev_dat_low = ~f[i];
            repeat (H) @(negedge clk);
            dev_clk_low = 1'b1;
            repeat (H) @(negedge clk);
            dev_clk_low = 1'b0;
        end
        dev_dat_low = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    // driver side of the scoreboard: queue the expected frame, then start it
    task automatic host_tx(input logic [7:0] b, input logic ack, input string tag);
        int wait_c;
        int prev;
        prev = frames_seen;
        dev_ack = ack;
        exp_q.push_back({1'b1, ~^b, b});
        wr(2'd2, b);
        wr(2'd0, 8'h02);
        wait_c = 0;
        while (clk_pull_low) begin
            @(negedge clk);
            wait_c++;
        end
        chk({tag, " R6 inhibit long enough"}, int'(wait_c >= INH - 1 && wait_c <= INH + 3), 1);
        chk({tag, " R6 start bit"}, dat_pull_low, 1);
        while (frames_seen == prev) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: device model pops the expected frame and compares the captured bits
    always begin
        logic [9:0] got;
        logic [9:0] exp;
        wait (!rst && !clk_pull_low && dat_pull_low);
        for (int k = 0; k < 11; k++) begin
            if (k == 10) dev_dat_low = dev_ack;
            repeat (H) @(negedge clk);
            dev_clk_low = 1'b1;
            repeat (H) @(negedge clk);
            if (k < 10) got[k] = ps2_dat_line;
            dev_clk_low = 1'b0;
        end
        repeat (H) @(negedge clk);
        dev_dat_low = 1'b0;
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h3FF;
        chk("R7 transmitted bits", got, exp);
        frames_seen++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        chk("R1 clock inhibited", clk_pull_low, 1);
        chk("R1 data released", dat_pull_low, 0);

        // R2 and R3: upper bits ignored, receive-enable releases clock
        wr(2'd0, 8'hF9);
        rd(2'd0, v); chk("R2 ctrl readback", v, 8'h01);
        chk("R3 clock released", clk_pull_low, 0);

        // R4 good frame
        dev_send(8'hA5, 1'b0, 1'b0);
        rd(2'd1, v); chk("R4 status done", v, 8'h01);
        rd(2'd2, v); chk("R4 byte", v, 8'hA5);
        rd(2'd0, v); chk("R4 enable cleared", v, 8'h00);
        chk("R4 clock inhibited", clk_pull_low, 1);

        // R4 second pattern, R11 status cleared on start
        wr(2'd0, 8'h01);
        rd(2'd1, v); chk("R11 status cleared", v, 8'h00);
        // R11 writes while busy are ignored
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h77);
        rd(2'd0, v); chk("R11 ctrl unchanged", v, 8'h01);
        chk("R11 clock still released", clk_pull_low, 0);
        dev_send(8'h00, 1'b0, 1'b0);
        rd(2'd2, v); chk("R4 byte zero", v, 8'h00);
        rd(2'd1, v); chk("R4 status", v, 8'h01);

        // R5 parity error, then stop error
        wr(2'd0, 8'h01);
        dev_send(8'h3C, 1'b1, 1'b0);
        rd(2'd1, v); chk("R5 parity error", v, 8'h05);
        wr(2'd0, 8'h01);
        dev_send(8'hC3, 1'b0, 1'b1);
        rd(2'd1, v); chk("R5 stop error", v, 8'h05);

        // R6-R8 transmit with ack
        host_tx(8'h96, 1'b1, "tx1");
        rd(2'd1, v); chk("R8 status done", v, 8'h01);
        rd(2'd0, v); chk("R8 enable cleared", v, 8'h00);
        chk("R8 clock inhibited", clk_pull_low, 1);
        host_tx(8'h00, 1'b1, "tx2");
        rd(2'd1, v); chk("R8 status done 2", v, 8'h01);
        // R8 missing ack
        host_tx(8'h5B, 1'b0, "tx3");
        rd(2'd1, v); chk("R8 ack error", v, 8'h05);

        // R9 abort request during receive
        wr(2'd0, 8'h01);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h04);
        rd(2'd1, v); chk("R9 status", v, 8'h03);
        rd(2'd0, v); chk("R9 ctrl", v, 8'h00);
        chk("R9 clock inhibited", clk_pull_low, 1);

        // R10 cancel by all-zero write during transmit hold
        wr(2'd2, 8'h81);
        wr(2'd0, 8'h02);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R10 status", v, 8'h03);
        rd(2'd0, v); chk("R10 ctrl", v, 8'h00);
        chk("R10 data released", dat_pull_low, 0);
        repeat (2 * INH) @(negedge clk);
        chk("R10 clock stays inhibited", clk_pull_low, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule